// File: doc/BRIEF.md
# Two-Channel Edge and Level Trigger

This block decides, once per clock (every clock edge takes one sample), whether a 16-bit sampled input bus meets a programmed trigger condition. It has two modes.

In pattern mode the sample is checked against a value under a bit mask. In edge mode two channel slots each pick one input channel and apply one of eight level or edge operators to it. The two slot results are then merged by one of six two-input logic functions. Edges are found by comparing the current sample with the sample registered one clock earlier.

When the condition holds while the detector is armed, the block emits a one-cycle trigger pulse and sets a sticky triggered flag. It then counts a programmed number of post-trigger samples and raises a done flag. A software force input fires the trigger without any match. A reset control clears the trigger state so that a new capture can start.

Top module: `edge_level_trigger`

## Requirements
- R1: After `rst_n` is released, `trig_pulse`, `triggered` and `post_done` are all 0.
- R2: With `cfg_mode`=0 the condition holds for a sample when `(smp_in ^ cfg_value) & cfg_mask` is zero, so an all-zero mask matches every sample.
- R3: With `cfg_mode`=1 each slot applies the operator coded in its 3-bit `cfg_op_*` field to bit `cfg_chan_*` of the sample. The codes are: 0 high level, 1 low level, 2 rising, 3 falling, 4 rising or falling, 5 not rising, 6 not falling, 7 neither rising nor falling. A rise is previous 0 with current 1, and a fall is previous 1 with current 0.
- R4: In edge mode the slot results A and B are combined by `cfg_func`: 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR, 5 XNOR. Codes 6 and 7 never match.
- R5: The first sample after `arm` rises, and the first sample after a `trig_rst` cycle, have no valid previous sample. For that sample operators 2 to 4 are false and operators 5 to 7 are true.
- R6: While `arm` is 0 no trigger fires, whatever the samples or `force_trig`. An already set `triggered` stays set.
- R7: A sample that meets the condition while armed and not yet triggered sets `triggered` and gives `trig_pulse`=1 for exactly the following cycle. Later matches give no further pulse, and `triggered` stays 1 until `trig_rst`.
- R8: A cycle with `trig_rst`=1 clears `triggered`, `post_done` and `trig_pulse` on the next edge, and takes priority over a match or a force in that same cycle.
- R9: `force_trig`=1 while armed and not triggered fires the trigger exactly as a match would.
- R10: `post_done` rises `cfg_post_len`+1 clock edges after `triggered` rises, and it stays 1 until `trig_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | 16 | Sampled input bus |
| cfg_mode | input | 1 | 0 pattern mode, 1 edge mode |
| cfg_mask | input | 16 | Pattern mode bit mask |
| cfg_value | input | 16 | Pattern mode compare value |
| cfg_chan_a | input | 4 | Channel index for slot A |
| cfg_op_a | input | 3 | Operator code for slot A |
| cfg_chan_b | input | 4 | Channel index for slot B |
| cfg_op_b | input | 3 | Operator code for slot B |
| cfg_func | input | 3 | Combining function code |
| cfg_post_len | input | 16 | Post-trigger sample count |
| arm | input | 1 | Detector enable |
| trig_rst | input | 1 | Clears the trigger state |
| force_trig | input | 1 | Software trigger request |
| trig_pulse | output | 1 | One-cycle trigger event |
| triggered | output | 1 | Sticky trigger flag |
| post_done | output | 1 | Post-trigger phase finished |

## Verification
The hardest situation to reach from the ports is a real edge on the very sample where the previous-sample history is invalid. Without care, the stimulus only ever sees edges between two samples that are both armed. The bench therefore holds a channel low while disarmed and then raises `arm` and the channel together. It also pulses `trig_rst` between every operator and function pairing, while a pseudo-random bus keeps changing. The bench's reference model is compared on every clock, so both the suppressed edge and the inverted operators' forced-true result are seen across all 64 pairings.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [2:0] {
    OP_HIGH   = 3'd0,
    OP_LOW    = 3'd1,
    OP_RISE   = 3'd2,
    OP_FALL   = 3'd3,
    OP_EDGE   = 3'd4,
    OP_NRISE  = 3'd5,
    OP_NFALL  = 3'd6,
    OP_NEDGE  = 3'd7
  } chan_op_e;

  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_NAND = 3'd1,
    FN_OR   = 3'd2,
    FN_NOR  = 3'd3,
    FN_XOR  = 3'd4,
    FN_XNOR = 3'd5,
    FN_OFF6 = 3'd6,
    FN_OFF7 = 3'd7
  } comb_fn_e;

  // Operator on one channel: cur/prev bit plus history validity.
  function automatic logic eval_op(input chan_op_e op, input logic cur,
                                   input logic prev, input logic hok);
    logic up, dn;
    up = hok & ~prev & cur;
    dn = hok & prev & ~cur;
    case (op)
      OP_HIGH:  eval_op = cur;
      OP_LOW:   eval_op = ~cur;
      OP_RISE:  eval_op = up;
      OP_FALL:  eval_op = dn;
      OP_EDGE:  eval_op = up | dn;
      OP_NRISE: eval_op = ~up;
      OP_NFALL: eval_op = ~dn;
      default:  eval_op = ~(up | dn);
    endcase
  endfunction

  function automatic logic combine(input comb_fn_e fn, input logic a, input logic b);
    case (fn)
      FN_AND:  combine = a & b;
      FN_NAND: combine = ~(a & b);
      FN_OR:   combine = a | b;
      FN_NOR:  combine = ~(a | b);
      FN_XOR:  combine = a ^ b;
      FN_XNOR: combine = ~(a ^ b);
      default: combine = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/trig_history.sv
module trig_history #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp_in,
  input  logic         arm,
  input  logic         trig_rst,
  output logic [W-1:0] prev_q,
  output logic         hist_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      hist_ok <= 1'b0;
    end else begin
      prev_q  <= smp_in;
      hist_ok <= arm & ~trig_rst;
    end
  end
endmodule

// File: rtl/trig_chan_op.sv
module trig_chan_op #(
  parameter int W   = 16,
  parameter int CHW = $clog2(W)
) (
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   prev,
  input  logic           hist_ok,
  input  logic [CHW-1:0] chan,
  input  logic [2:0]     op,
  output logic           res
);
  logic cur_bit, prev_bit;
  assign cur_bit  = cur[chan];
  assign prev_bit = prev[chan];
  assign res = trig_pkg::eval_op(trig_pkg::chan_op_e'(op), cur_bit, prev_bit, hist_ok);
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             trig_rst,
  input  logic             hit,
  input  logic             force_trig,
  input  logic [CNT_W-1:0] post_len,
  output logic             fire,
  output logic             trig_pulse,
  output logic             triggered,
  output logic             post_done
);
  logic [CNT_W-1:0] post_cnt;

  assign fire = arm & ~triggered & (hit | force_trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_pulse <= 1'b0;
      triggered  <= 1'b0;
      post_done  <= 1'b0;
      post_cnt   <= '0;
    end else if (trig_rst) begin
      trig_pulse <= 1'b0;
      triggered  <= 1'b0;
      post_done  <= 1'b0;
      post_cnt   <= '0;
    end else begin
      trig_pulse <= fire;
      if (fire) begin
        triggered <= 1'b1;
        post_cnt  <= '0;
      end else if (triggered && !post_done) begin
        if (post_cnt == post_len) post_done <= 1'b1;
        else                      post_cnt  <= post_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/edge_level_trigger.sv
module edge_level_trigger #(
  parameter int W     = 16,
  parameter int CNT_W = 16,
  localparam int CHW  = $clog2(W),
  localparam int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     smp_in,
  input  logic             cfg_mode,
  input  logic [W-1:0]     cfg_mask,
  input  logic [W-1:0]     cfg_value,
  input  logic [CHW-1:0]   cfg_chan_a,
  input  logic [2:0]       cfg_op_a,
  input  logic [CHW-1:0]   cfg_chan_b,
  input  logic [2:0]       cfg_op_b,
  input  logic [2:0]       cfg_func,
  input  logic [CNT_W-1:0] cfg_post_len,
  input  logic             arm,
  input  logic             trig_rst,
  input  logic             force_trig,
  output logic             trig_pulse,
  output logic             triggered,
  output logic             post_done
);
  logic [W-1:0]   prev_q;
  logic           hist_ok;
  logic [CHW-1:0] slot_chan [NSLOT];
  logic [2:0]     slot_op   [NSLOT];
  logic [NSLOT-1:0] slot_res;
  logic           pat_hit, edge_hit, hit, fire;

  assign slot_chan[0] = cfg_chan_a;
  assign slot_chan[1] = cfg_chan_b;
  assign slot_op[0]   = cfg_op_a;
  assign slot_op[1]   = cfg_op_b;

  trig_history #(.W(W)) u_hist (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .arm(arm),
    .trig_rst(trig_rst), .prev_q(prev_q), .hist_ok(hist_ok)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    trig_chan_op #(.W(W), .CHW(CHW)) u_op (
      .cur(smp_in), .prev(prev_q), .hist_ok(hist_ok),
      .chan(slot_chan[s]), .op(slot_op[s]), .res(slot_res[s])
    );
  end

  assign pat_hit  = ~|((smp_in ^ cfg_value) & cfg_mask);
  assign edge_hit = trig_pkg::combine(trig_pkg::comb_fn_e'(cfg_func), slot_res[0], slot_res[1]);
  assign hit      = cfg_mode ? edge_hit : pat_hit;

  trig_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_rst(trig_rst), .hit(hit),
    .force_trig(force_trig), .post_len(cfg_post_len), .fire(fire),
    .trig_pulse(trig_pulse), .triggered(triggered), .post_done(post_done)
  );
endmodule

// File: rtl/trig_checker.sv
module trig_checker (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic trig_rst,
  input logic force_trig,
  input logic hist_ok,
  input logic trig_pulse,
  input logic triggered,
  input logic post_done
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse); // R7
  AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> triggered); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !trig_rst) |=> triggered); // R7
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rst |=> (!triggered && !post_done && !trig_pulse)); // R8
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !trig_pulse); // R6
  AST_FORCE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && force_trig && !trig_rst && !triggered) |=> trig_pulse); // R9
  AST_DONE_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    post_done |-> triggered); // R10
  AST_NO_HISTORY_ON_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm) |-> !hist_ok); // R5
endmodule

bind edge_level_trigger trig_checker u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .trig_rst(trig_rst),
  .force_trig(force_trig), .hist_ok(hist_ok), .trig_pulse(trig_pulse),
  .triggered(triggered), .post_done(post_done)
);

// File: tb/tb_edge_level_trigger.sv
module tb_edge_level_trigger;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] smp_in = '0;
  logic cfg_mode = 1'b0;
  logic [15:0] cfg_mask = '0, cfg_value = '0;
  logic [3:0] cfg_chan_a = '0, cfg_chan_b = '0;
  logic [2:0] cfg_op_a = '0, cfg_op_b = '0, cfg_func = '0;
  logic [15:0] cfg_post_len = '0;
  logic arm = 1'b0, trig_rst = 1'b0, force_trig = 1'b0;
  logic trig_pulse, triggered, post_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_level_trigger dut (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .cfg_mode(cfg_mode),
    .cfg_mask(cfg_mask), .cfg_value(cfg_value), .cfg_chan_a(cfg_chan_a),
    .cfg_op_a(cfg_op_a), .cfg_chan_b(cfg_chan_b), .cfg_op_b(cfg_op_b),
    .cfg_func(cfg_func), .cfg_post_len(cfg_post_len), .arm(arm),
    .trig_rst(trig_rst), .force_trig(force_trig), .trig_pulse(trig_pulse),
    .triggered(triggered), .post_done(post_done)
  );

  int n_checks = 0, n_fail = 0;
  string phase = "R1";
  bit cmp_on = 1'b0;

  // Reference model state
  logic [15:0] m_prev;
  bit m_hist, m_trig, m_pulse, m_done;
  int m_count;

  function automatic bit ref_op(int op, bit c, bit p, bit ok);
    bit r = ok && !p && c;
    bit f = ok && p && !c;
    if (op == 0) return c;
    if (op == 1) return !c;
    if (op == 2) return r;
    if (op == 3) return f;
    if (op == 4) return r || f;
    if (op == 5) return !r;
    if (op == 6) return !f;
    return !(r || f);
  endfunction

  function automatic bit ref_fn(int fn, bit a, bit b);
    int ones = int'(a) + int'(b);
    case (fn)
      0: return ones == 2;
      1: return ones != 2;
      2: return ones >= 1;
      3: return ones == 0;
      4: return ones == 1;
      5: return ones != 1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit ref_hit();
    bit a, b;
    if (!cfg_mode) begin
      for (int i = 0; i < 16; i++)
        if (cfg_mask[i] && (smp_in[i] != cfg_value[i])) return 1'b0;
      return 1'b1;
    end
    a = ref_op(int'(cfg_op_a), smp_in[cfg_chan_a], m_prev[cfg_chan_a], m_hist);
    b = ref_op(int'(cfg_op_b), smp_in[cfg_chan_b], m_prev[cfg_chan_b], m_hist);
    return ref_fn(int'(cfg_func), a, b);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = '0; m_hist = 0; m_trig = 0; m_pulse = 0; m_done = 0; m_count = 0;
    end else if (trig_rst) begin
      m_trig = 0; m_pulse = 0; m_done = 0; m_count = 0;
      m_prev = smp_in; m_hist = 0;
    end else begin
      bit go;
      go = arm && !m_trig && (force_trig || ref_hit());
      m_pulse = go;
      if (go) begin
        m_trig = 1; m_count = 0;
      end else if (m_trig && !m_done) begin
        if (m_count == int'(cfg_post_len)) m_done = 1;
        else m_count++;
      end
      m_prev = smp_in; m_hist = arm;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(phase, "trig_pulse", int'(trig_pulse), int'(m_pulse));
      check(phase, "triggered", int'(triggered), int'(m_trig));
      check(phase, "post_done", int'(post_done), int'(m_done));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_trig();
    trig_rst = 1'b1; cyc(1); trig_rst = 1'b0;
  endtask

  logic [15:0] lfsr = 16'hACE1;
  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    smp_in = lfsr;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check("R1", "reset pulse", int'(trig_pulse), 0);
    check("R1", "reset triggered", int'(triggered), 0);
    check("R1", "reset done", int'(post_done), 0);
    cmp_on = 1'b1;

    // R2 pattern mode
    phase = "R2";
    cfg_mode = 1'b0; cfg_mask = 16'h00F0; cfg_value = 16'h0050; cfg_post_len = 16'd2;
    arm = 1'b1;
    smp_in = 16'h1234; cyc(3);
    smp_in = 16'hFF5F; cyc(1);
    check("R2", "match triggered", int'(triggered), 1);
    check("R7", "match pulse", int'(trig_pulse), 1);
    phase = "R7";
    smp_in = 16'h0050; cyc(2);
    check("R7", "no second pulse", int'(trig_pulse), 0);
    phase = "R10"; cyc(3);
    check("R10", "post done", int'(post_done), 1);

    // R8 reset beats force and match
    phase = "R8";
    trig_rst = 1'b1; force_trig = 1'b1; cyc(1);
    trig_rst = 1'b0; force_trig = 1'b0;
    check("R8", "rst clears flag", int'(triggered), 0);
    check("R8", "rst clears done", int'(post_done), 0);

    // R6 / R9 disarmed, then force
    phase = "R6";
    smp_in = 16'h0000; cyc(1);
    arm = 1'b0; cfg_mask = '0; force_trig = 1'b1; cyc(4);
    check("R6", "disarmed no trigger", int'(triggered), 0);
    phase = "R9";
    arm = 1'b1; cfg_mask = 16'hFFFF; cfg_value = 16'hFFFF; cyc(1);
    force_trig = 1'b0;
    check("R9", "force triggers", int'(triggered), 1);
    phase = "R6";
    arm = 1'b0; cyc(3);
    check("R6", "flag held disarmed", int'(triggered), 1);

    // R5 first sample after arming carries no edge
    phase = "R5";
    clear_trig();
    cfg_mode = 1'b1; cfg_chan_a = 4'd3; cfg_chan_b = 4'd3;
    cfg_op_a = 3'd2; cfg_op_b = 3'd2; cfg_func = 3'd0; cfg_post_len = 16'd0;
    smp_in = 16'h0000; cyc(2);
    arm = 1'b1; smp_in = 16'h0008; cyc(1);
    check("R5", "no edge on first armed sample", int'(triggered), 0);
    smp_in = 16'h0000; cyc(1);
    smp_in = 16'h0008; cyc(1);
    check("R5", "edge once history valid", int'(triggered), 1);
    cyc(1);
    check("R10", "zero length done", int'(post_done), 1);

    // R3/R4 sweep of all operator and function codes
    phase = "R3,R4";
    for (int op = 0; op < 8; op++) begin
      for (int fn = 0; fn < 8; fn++) begin
        cfg_op_a = 3'(op); cfg_op_b = 3'(7 - op); cfg_func = 3'(fn);
        cfg_chan_a = 4'((op * 5 + fn) % 16); cfg_chan_b = 4'((fn * 3 + 1) % 16);
        cfg_post_len = 16'(fn % 4);
        next_rand();
        clear_trig();
        arm = 1'b1;
        for (int k = 0; k < 11; k++) begin
          next_rand();
          force_trig = (fn == 7 && k == 6);
          arm = !(op == 3 && k == 4);
          cyc(1);
        end
        force_trig = 1'b0; arm = 1'b1;
      end
    end

    cmp_on = 1'b0;
    finish_run();
  end
endmodule